// File: doc/BRIEF.md
# Debounced Wakeup Event Controller

This block monitors two general-purpose input ports, port A (32 pins by default) and port B (23 pins by default), and turns a qualifying key-hit condition into a wakeup interrupt. Software chooses which pins take part, and which level counts as active on each pin. Software can also emulate a key hit without any pin activity. The combined key-hit condition is debounced in whole milliseconds by a timer driven from the system clock. When the condition survives the debounce window, the block raises a level interrupt. The interrupt stays high until software writes the interrupt-reset register.

Every pin also has a sticky toggle-status bit. This bit records any change of the synchronised pin, in either direction, whether or not the pin is selected. Software clears the bit by writing 1 to the matching bit of a clear register.

A simple register bus gives access to all settings. It takes a write strobe, a byte address and write data, and returns read data combinationally for the addressed register. The register bank also stores a second per-pin select mask for each port, reserved for a separate GPIO interrupt path.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `wake_irq_o` is 0.
- R2: The key-hit condition is true when either of the following holds:
  - some pin whose bit is set in its port's select register (0x14 for A, 0x18 for B) has a level that differs from its polarity bit (0x28 for A, 0x2C for B). Polarity 0 means active high and polarity 1 means active low. Pins that are not selected have no effect.
  - the soft key-hit bit (bit 6 of the control register at 0x00) is 1.
- R3: With debounce count N = 1..63 (control bits [5:0]), an event fires after the condition has held for N full milliseconds of `CYC_PER_MS` cycles each. Any drop of the condition restarts the window from zero.
- R4: With N = 0, an event fires in the first cycle in which the condition is true, with no debounce delay.
- R5: A soft key hit produces one event. A further soft hit is accepted only after bit 6 has been written back to 0.
- R6: An event raises the interrupt only if bit 7 of the control register is 1. An event that occurs while the bit is 0 is lost.
- R7: The interrupt is a level that holds until any value is written to 0x08. A set in the same cycle as that write wins. Reading 0x08 returns 0.
- R8: The status registers (0x3C for A, 0x40 for B) latch a 1 in bit i on any change of pin i of that port. The bits are sticky and independent of the select registers.
- R9: Writing 1 to a bit of a clear register (0x48 for A, 0x4C for B) clears that status bit, and writing 0 leaves it unchanged. The clear registers read as 0. Writes to the status addresses are ignored.
- R10: The control, select, polarity and GPIO-select registers (0x54 for A, 0x58 for B) read back what was written. Control bits above 7 and bits above a port's width read as 0, and unmapped addresses read 0.
- R11: One sustained key-hit condition produces at most one event. After the interrupt is reset, it is not raised again until the condition has dropped and returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_i | input | PA_W | Port A pins, asynchronous |
| port_b_i | input | PB_W | Port B pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| wake_irq_o | output | 1 | Wakeup interrupt level |

## Verification
The bench builds the block with `CYC_PER_MS` = 4 and the default port widths of 32 and 23. A 4-cycle millisecond makes the longest window of 63 ms only 252 cycles, so the bench can check the exact firing cycle for both the minimum and the maximum debounce counts. The same setting makes a restart after a dropped condition visible as a precise delay shift. Keeping port B at 23 pins puts its highest pin and the zero-reading bits above it within reach of the checks.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
   // control register field layout
   localparam int DEB_W     = 6;
   localparam int SOFT_BIT  = 6;
   localparam int EN_BIT    = 7;
   // register byte offsets
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_IRST   = 'h08;
   localparam int OFS_SEL_A  = 'h14;
   localparam int OFS_SEL_B  = 'h18;
   localparam int OFS_POL_A  = 'h28;
   localparam int OFS_POL_B  = 'h2C;
   localparam int OFS_STAT_A = 'h3C;
   localparam int OFS_STAT_B = 'h40;
   localparam int OFS_CLR_A  = 'h48;
   localparam int OFS_CLR_B  = 'h4C;
   localparam int OFS_GSEL_A = 'h54;
   localparam int OFS_GSEL_B = 'h58;
   localparam int MIN_ADDR_W = 7;
endpackage

// File: rtl/wkc_sync.sv
module wkc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] toggle
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wkc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("wkc_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] q_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q_prev <= '0;
      else        q_prev <= chain[STAGES-1];

   assign q      = chain[STAGES-1];
   assign toggle = q ^ q_prev;
endmodule

// File: rtl/wkc_ms_tick.sv
module wkc_ms_tick #(
   parameter int CYC_PER_MS = 32000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (CYC_PER_MS < 1) begin : g_bad_cpm
      $error("wkc_ms_tick: CYC_PER_MS must be positive");
   end

   if (CYC_PER_MS == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(CYC_PER_MS);
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);
      logic [CW-1:0] cnt;

      assign tick = run && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)             cnt <= '0;
         else if (!run || tick)  cnt <= '0;
         else                    cnt <= cnt + CW'(1);

      // R3: ticks of a multi-cycle millisecond are never back to back
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/wkc_debounce.sv
module wkc_debounce #(
   parameter int N_W = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cond,
   input  logic           tick,
   input  logic [N_W-1:0] limit,
   output logic           fire
);
   if (N_W < 1) begin : g_bad_nw
      $error("wkc_debounce: N_W must be positive");
   end

   logic [N_W-1:0] tcnt;
   logic           done;
   logic           bypass;
   logic           reach;

   assign bypass = (limit == '0);
   assign reach  = tick && (tcnt == limit - N_W'(1));
   assign fire   = cond && !done && (bypass || reach);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         tcnt <= '0;
         done <= 1'b0;
      end else if (!cond) begin
         tcnt <= '0;
         done <= 1'b0;
      end else begin
         if (fire)          done <= 1'b1;
         if (tick && !done) tcnt <= tcnt + N_W'(1);
      end

   // R11: one sustained condition yields a single event
   p_single_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   // R3: with no condition the window is not running
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> !fire || bypass);
endmodule

// File: rtl/wkc_regs.sv
module wkc_regs
   import wkc_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter int PB_W   = 23,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [PA_W-1:0]   tog_a,
   input  logic [PB_W-1:0]   tog_b,
   output logic [DEB_W-1:0]  deb_n,
   output logic              soft_hit,
   output logic              irq_en,
   output logic [PA_W-1:0]   sel_a,
   output logic [PA_W-1:0]   pol_a,
   output logic [PB_W-1:0]   sel_b,
   output logic [PB_W-1:0]   pol_b,
   output logic              irq_rst_wr
);
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("wkc_regs: ADDR_W too small for the register map");
   end
   if (DATA_W < PA_W || DATA_W < PB_W || DATA_W < EN_BIT + 1) begin : g_bad_data
      $error("wkc_regs: DATA_W narrower than a register");
   end

   logic hit_ctrl, hit_irst, hit_sel_a, hit_sel_b, hit_pol_a, hit_pol_b;
   logic hit_stat_a, hit_stat_b, hit_clr_a, hit_clr_b, hit_gsel_a, hit_gsel_b;

   assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
   assign hit_irst   = (addr == ADDR_W'(OFS_IRST));
   assign hit_sel_a  = (addr == ADDR_W'(OFS_SEL_A));
   assign hit_sel_b  = (addr == ADDR_W'(OFS_SEL_B));
   assign hit_pol_a  = (addr == ADDR_W'(OFS_POL_A));
   assign hit_pol_b  = (addr == ADDR_W'(OFS_POL_B));
   assign hit_stat_a = (addr == ADDR_W'(OFS_STAT_A));
   assign hit_stat_b = (addr == ADDR_W'(OFS_STAT_B));
   assign hit_clr_a  = (addr == ADDR_W'(OFS_CLR_A));
   assign hit_clr_b  = (addr == ADDR_W'(OFS_CLR_B));
   assign hit_gsel_a = (addr == ADDR_W'(OFS_GSEL_A));
   assign hit_gsel_b = (addr == ADDR_W'(OFS_GSEL_B));

   logic [DEB_W-1:0] deb_q;
   logic             soft_q, en_q;
   logic [PA_W-1:0]  sel_a_q, pol_a_q, gsel_a_q, stat_a_q, clr_a;
   logic [PB_W-1:0]  sel_b_q, pol_b_q, gsel_b_q, stat_b_q, clr_b;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         deb_q    <= '0;
         soft_q   <= 1'b0;
         en_q     <= 1'b0;
         sel_a_q  <= '0;
         pol_a_q  <= '0;
         gsel_a_q <= '0;
         sel_b_q  <= '0;
         pol_b_q  <= '0;
         gsel_b_q <= '0;
      end else if (we) begin
         if (hit_ctrl) begin
            deb_q  <= wdata[DEB_W-1:0];
            soft_q <= wdata[SOFT_BIT];
            en_q   <= wdata[EN_BIT];
         end
         if (hit_sel_a)  sel_a_q  <= wdata[PA_W-1:0];
         if (hit_pol_a)  pol_a_q  <= wdata[PA_W-1:0];
         if (hit_gsel_a) gsel_a_q <= wdata[PA_W-1:0];
         if (hit_sel_b)  sel_b_q  <= wdata[PB_W-1:0];
         if (hit_pol_b)  pol_b_q  <= wdata[PB_W-1:0];
         if (hit_gsel_b) gsel_b_q <= wdata[PB_W-1:0];
      end

   assign clr_a = (we && hit_clr_a) ? wdata[PA_W-1:0] : '0;
   assign clr_b = (we && hit_clr_b) ? wdata[PB_W-1:0] : '0;

   // a fresh toggle outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         stat_a_q <= '0;
         stat_b_q <= '0;
      end else begin
         stat_a_q <= (stat_a_q & ~clr_a) | tog_a;
         stat_b_q <= (stat_b_q & ~clr_b) | tog_b;
      end

   always_comb begin
      rdata = '0;
      if (hit_ctrl)   rdata = DATA_W'({en_q, soft_q, deb_q});
      if (hit_sel_a)  rdata = DATA_W'(sel_a_q);
      if (hit_sel_b)  rdata = DATA_W'(sel_b_q);
      if (hit_pol_a)  rdata = DATA_W'(pol_a_q);
      if (hit_pol_b)  rdata = DATA_W'(pol_b_q);
      if (hit_stat_a) rdata = DATA_W'(stat_a_q);
      if (hit_stat_b) rdata = DATA_W'(stat_b_q);
      if (hit_gsel_a) rdata = DATA_W'(gsel_a_q);
      if (hit_gsel_b) rdata = DATA_W'(gsel_b_q);
   end

   assign deb_n      = deb_q;
   assign soft_hit   = soft_q;
   assign irq_en     = en_q;
   assign sel_a      = sel_a_q;
   assign pol_a      = pol_a_q;
   assign sel_b      = sel_b_q;
   assign pol_b      = pol_b_q;
   assign irq_rst_wr = we && hit_irst;

   // R8: status bits only fall through a clear write
   p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && hit_clr_a) |=> ((stat_a_q & $past(stat_a_q)) == $past(stat_a_q)));
   // R9: cleared bits without a concurrent toggle read 0 afterwards
   p_clr_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit_clr_b) |=> ((stat_b_q & $past(wdata[PB_W-1:0] & ~tog_b)) == '0));
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
   import wkc_pkg::*;
#(
   parameter int PA_W        = 32,
   parameter int PB_W        = 23,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int CYC_PER_MS  = 32000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PA_W-1:0]   port_a_i,
   input  logic [PB_W-1:0]   port_b_i,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wake_irq_o
);
   logic [PA_W-1:0]  sync_a, tog_a, sel_a, pol_a;
   logic [PB_W-1:0]  sync_b, tog_b, sel_b, pol_b;
   logic [DEB_W-1:0] deb_n;
   logic             soft_hit, irq_en, irq_rst_wr;
   logic             key_hit, ms_tick, fire, irq_q;

   wkc_sync #(.W(PA_W), .STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .d(port_a_i), .q(sync_a), .toggle(tog_a));

   wkc_sync #(.W(PB_W), .STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .d(port_b_i), .q(sync_b), .toggle(tog_b));

   wkc_regs #(.PA_W(PA_W), .PB_W(PB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .tog_a(tog_a), .tog_b(tog_b), .deb_n(deb_n),
      .soft_hit(soft_hit), .irq_en(irq_en), .sel_a(sel_a), .pol_a(pol_a),
      .sel_b(sel_b), .pol_b(pol_b), .irq_rst_wr(irq_rst_wr));

   assign key_hit = (|(sel_a & (sync_a ^ pol_a))) |
                    (|(sel_b & (sync_b ^ pol_b))) | soft_hit;

   wkc_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(key_hit), .tick(ms_tick));

   wkc_debounce #(.N_W(DEB_W)) u_deb (
      .clk(clk), .rst_n(rst_n), .cond(key_hit), .tick(ms_tick),
      .limit(deb_n), .fire(fire));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              irq_q <= 1'b0;
      else if (fire && irq_en) irq_q <= 1'b1;
      else if (irq_rst_wr)     irq_q <= 1'b0;

   assign wake_irq_o = irq_q;

   // R7: interrupt level holds until the reset register is written
   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_rst_wr) |=> irq_q);
   // R7: an enabled event beats a simultaneous reset write
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && irq_en) |=> irq_q);
   // R6: interrupt only rises when enabled
   p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(irq_en));
endmodule

// File: tb/sim_wake_evt_ctrl.sv
module sim_wake_evt_ctrl;
   localparam int CPM = 4;
   localparam logic [6:0] A_CTRL = 7'h00, A_IRST = 7'h08, A_SELA = 7'h14,
      A_SELB = 7'h18, A_POLA = 7'h28, A_POLB = 7'h2C, A_STA = 7'h3C,
      A_STB = 7'h40, A_CLRA = 7'h48, A_CLRB = 7'h4C, A_GSA = 7'h54,
      A_GSB = 7'h58, A_NONE = 7'h04;

   typedef struct packed {
      logic [31:0] sel_a, pol_a, pin_a;
      logic [7:0]  sel_b, pol_b, pin_b;
      logic [5:0]  deb;
      logic        expect_irq;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{32'h1,        32'h0,        32'h1,        8'h0,  8'h0,  8'h0,  6'd0,  1'b1}, // R4
      '{32'h80000000, 32'h0,        32'h80000000, 8'h0,  8'h0,  8'h0,  6'd2,  1'b1}, // R3
      '{32'h10,       32'h10,       32'h0,        8'h0,  8'h0,  8'h0,  6'd1,  1'b1}, // R2 low active
      '{32'h10,       32'h10,       32'h10,       8'h0,  8'h0,  8'h0,  6'd1,  1'b0}, // R2 inactive
      '{32'h0F,       32'h0,        32'hF0,       8'h0,  8'h0,  8'h0,  6'd1,  1'b0}, // R2 unselected
      '{32'h0,        32'h0,        32'h0,        8'h08, 8'h0,  8'h08, 6'd3,  1'b1}, // R2 port B
      '{32'h0,        32'h0,        32'h0,        8'h01, 8'h01, 8'h00, 6'd63, 1'b1}, // R3 max N
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h0,  8'h0,  8'h0,  6'd1,  1'b0}  // R2 all idle
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_a = '0;
   logic [22:0] pin_b = '0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   wake_evt_ctrl #(.CYC_PER_MS(CPM)) u0 (
      .clk(clk), .rst_n(rst_n), .port_a_i(pin_a), .port_b_i(pin_b),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wake_irq_o(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp_v);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp_v);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd_chk("R1 ctrl", A_CTRL, 0);  rd_chk("R1 sela", A_SELA, 0);
      rd_chk("R1 selb", A_SELB, 0);  rd_chk("R1 pola", A_POLA, 0);
      rd_chk("R1 polb", A_POLB, 0);  rd_chk("R1 sta", A_STA, 0);
      rd_chk("R1 stb", A_STB, 0);    rd_chk("R1 gsa", A_GSA, 0);
      rd_chk("R1 gsb", A_GSB, 0);

      // R10 readback and width masking
      wr(A_CTRL, 32'hFFFFFF3F);  rd_chk("R10 ctrl", A_CTRL, 32'h3F);
      wr(A_SELB, 32'hFFFFFFFF);  rd_chk("R10 selb", A_SELB, 32'h007FFFFF);
      wr(A_POLA, 32'h12345678);  rd_chk("R10 pola", A_POLA, 32'h12345678);
      wr(A_GSA, 32'hA5A5A5A5);   rd_chk("R10 gsa", A_GSA, 32'hA5A5A5A5);
      wr(A_GSB, 32'hFFFFFFFF);   rd_chk("R10 gsb", A_GSB, 32'h007FFFFF);
      wr(A_CLRA, 32'h0);         rd_chk("R9 clra reads 0", A_CLRA, 0);
      rd_chk("R7 irst reads 0", A_IRST, 0);
      rd_chk("R10 unmapped", A_NONE, 0);
      wr(A_SELB, 0); wr(A_POLA, 0); wr(A_CTRL, 0);

      // table of pin patterns
      for (int v = 0; v < 8; v++) begin
         int d;
         wr(A_SELA, 0); wr(A_SELB, 0); wr(A_IRST, 0);
         wr(A_CTRL, {24'h0, 2'b10, TBL[v].deb});
         wr(A_POLA, TBL[v].pol_a);
         wr(A_POLB, {24'h0, TBL[v].pol_b});
         pin_a = TBL[v].pin_a;
         pin_b = {15'h0, TBL[v].pin_b};
         wait_n(4);
         if (TBL[v].sel_b != 0) begin
            wr(A_SELA, TBL[v].sel_a);
            wr(A_SELB, {24'h0, TBL[v].sel_b});
         end else begin
            wr(A_SELA, TBL[v].sel_a);
         end
         d = (TBL[v].deb == 0) ? 1 : int'(TBL[v].deb) * CPM;
         wait_n(d - 1);
         chk($sformatf("R3 vec%0d early", v), {31'b0, irq}, 32'h0);
         wait_n(1);
         chk($sformatf("R2 vec%0d", v), {31'b0, irq}, {31'b0, TBL[v].expect_irq});
      end
      wr(A_SELA, 0); wr(A_SELB, 0);
      pin_a = '0; pin_b = '0;
      wait_n(4);
      wr(A_IRST, 0);

      // R3 restart on a dropped condition
      wr(A_CTRL, 32'hC2);
      wait_n(4);
      wr(A_CTRL, 32'h82);
      wr(A_CTRL, 32'hC2);
      wait_n(7);
      chk("R3 restart early", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R3 restart fire", {31'b0, irq}, 32'h1);
      wr(A_CTRL, 32'h80); wr(A_IRST, 32'hDEAD);

      // R5 / R11 soft key hit
      wr(A_CTRL, 32'hC0);
      wait_n(1);
      chk("R4 soft bypass", {31'b0, irq}, 32'h1);
      rd_chk("R7 irst reads 0 while set", A_IRST, 0);
      wr(A_IRST, 32'h1234);
      chk("R7 cleared by write", {31'b0, irq}, 32'h0);
      wait_n(5);
      chk("R11 held soft no refire", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'h80);
      wr(A_CTRL, 32'hC0);
      wait_n(1);
      chk("R5 rearmed soft hit", {31'b0, irq}, 32'h1);
      wr(A_CTRL, 32'h80); wr(A_IRST, 0);

      // R7 set beats reset write in the same cycle, then holds
      wr(A_CTRL, 32'hC0);
      wr(A_IRST, 0);
      chk("R7 set wins", {31'b0, irq}, 32'h1);
      wait_n(10);
      chk("R7 level held", {31'b0, irq}, 32'h1);
      wr(A_CTRL, 32'h80); wr(A_IRST, 0);
      chk("R7 cleared", {31'b0, irq}, 32'h0);

      // R6 event lost while disabled
      wr(A_CTRL, 32'h40);
      wait_n(3);
      chk("R6 disabled", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'hC0);
      wait_n(3);
      chk("R6 no late irq", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 0);

      // R8 / R9 status latching and clearing
      wr(A_CLRA, 32'hFFFFFFFF); wr(A_CLRB, 32'hFFFFFFFF);
      rd_chk("R9 sta cleared", A_STA, 0);
      pin_a[5] = 1'b1;
      wait_n(4);
      rd_chk("R8 rise latched", A_STA, 32'h20);
      pin_a[5] = 1'b0;
      wait_n(4);
      rd_chk("R8 sticky", A_STA, 32'h20);
      wr(A_CLRA, 32'h0);
      rd_chk("R9 zero no effect", A_STA, 32'h20);
      wr(A_STA, 32'h0);
      rd_chk("R9 status read-only", A_STA, 32'h20);
      wr(A_CLRA, 32'h20);
      rd_chk("R9 clear one", A_STA, 0);
      pin_b[22] = 1'b1;
      wait_n(4);
      rd_chk("R8 port B top pin", A_STB, 32'h00400000);
      wr(A_CLRB, 32'h00400000);
      rd_chk("R9 port B clear", A_STB, 0);
      chk("R2 unselected pin no irq", {31'b0, irq}, 32'h0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule